// File: doc/BRIEF.md
# Serial Flash Write-Protect Guard

This block holds the protection state of a serial flash and decides, one command at a time, whether a write may go ahead. It keeps a status register with a retained lock bit, a three-bit protected-range code and a volatile write-enable latch. It samples an active-low write-protect pin through a synchronizer. Upstream command decoding presents single-cycle strobes: set write enable, write the status register with a data byte, and program or erase at an address. The array, the serial framing and the storage cells are outside the block.

Every write needs the enable latch first. A status write is blocked only when the lock bit is set and the synchronized pin is low. In that state the lock bit and the range code cannot change. Program and erase are refused inside the protected range whatever the pin level. A debug-lockout output follows the synchronized pin, so that debug paths stay shut while protection is asserted.

Top module: `flash_wp_guard`

## Requirements
- R1: Locked mode holds exactly when status bit 7 (lock) is 1 and the synchronized write-protect level is low.
- R2: In locked mode a status-write strobe yields a reject pulse and leaves status bits 7:2 unchanged.
- R3: In locked mode status bits 7:2 do not change on any command.
- R4: Status bits 7:2 keep their value across an assertion of rst_ni; the enable latch clears to 0.
- R5: With lock at 0 and the enable latch set, a status write is accepted at either pin level, loading bit 7 from data bit 7 and bits 4:2 from data bits 4:2.
- R6: debug_lock_o is high while the pin is low, following the pin after two rising clock edges; it is low out of reset.
- R7: The status byte holds lock at bit 7, the range code at bits 4:2, the enable latch at bit 1 and busy_i at bit 0; bits 6:5 read 0.
- R8: Range code 0 protects nothing. Codes 1 to 6 protect the top 1/64, 1/32, 1/16, 1/8, 1/4 and 1/2 of the 2^ADDR_W address space. Code 7 protects all of it. Program or erase inside the range is rejected.
- R9: Status write, program and erase are rejected when the enable latch is clear, and they clear the latch whether they are accepted or rejected.
- R10: A write-enable strobe sets the latch and yields an accept pulse.
- R11: Each strobe yields exactly one one-cycle accept or reject pulse on the cycle after the strobe; the two are never high together. If several strobes arrive in one cycle, status write wins, then program, then erase, then write enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wp_ni | input | 1 | Write-protect pin, active low, asynchronous |
| busy_i | input | 1 | Array busy flag, shown in the status byte |
| cmd_wren_i | input | 1 | Write-enable strobe |
| cmd_wrsr_i | input | 1 | Status-write strobe |
| wrsr_data_i | input | 8 | Status-write data byte |
| cmd_prog_i | input | 1 | Program strobe |
| cmd_erase_i | input | 1 | Erase strobe |
| addr_i | input | ADDR_W | Target address for program or erase |
| status_o | output | 8 | Status byte |
| accept_o | output | 1 | Command granted pulse |
| reject_o | output | 1 | Command refused pulse |
| debug_lock_o | output | 1 | Debug lockout while protection is asserted |

## Verification
The bench builds the block with ADDR_W = 10, so the address space has 1024 words. Each range boundary falls at a small, easy-to-hit address: 1008 for the 1/64 code, 960 for 1/16 and 512 for 1/2. The last unprotected address and the first protected one can both be tried directly. The narrow width also lets the whole-array code be checked at address 0 and the empty code at the top address. The default width needs the same decode with only the top-bit slices moved.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;
  localparam int SR_LOCK = 7;
  localparam int SR_RNG_HI = 4;
  localparam int SR_RNG_LO = 2;
  localparam int SR_WEL = 1;
  localparam int SR_BUSY = 0;
  localparam int RNG_W = SR_RNG_HI - SR_RNG_LO + 1;

  typedef enum logic [1:0] {OP_IDLE, OP_WREN, OP_WRSR, OP_ARRAY} op_e;

  typedef struct packed {
    logic             lock;
    logic [RNG_W-1:0] rng;
  } nv_t;

  function automatic logic [7:0] pack_status(nv_t nv, logic wel, logic busy);
    logic [7:0] s;
    s = '0;
    s[SR_LOCK] = nv.lock;
    s[SR_RNG_HI:SR_RNG_LO] = nv.rng;
    s[SR_WEL] = wel;
    s[SR_BUSY] = busy;
    return s;
  endfunction
endpackage

// File: rtl/wp_sync.sv
module wp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  // reset to the deasserted (high) pin level
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;
    else         chain_q <= {chain_q[STAGES-2:0], async_i};
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/wp_region.sv
module wp_region #(
  parameter int ADDR_W = 24,
  parameter int RNG_W  = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [RNG_W-1:0]  rng_i,
  output logic              hit_o
);
  localparam int CODES  = 1 << RNG_W;
  localparam int LEVELS = CODES - 2;

  logic [CODES-1:0] lvl;

  assign lvl[0]       = 1'b0;
  assign lvl[CODES-1] = 1'b1;

  // code k guards the top 2^-(LEVELS+1-k) fraction: top address bits all ones
  for (genvar k = 1; k <= LEVELS; k++) begin : g_lvl
    localparam int TOPB = LEVELS + 1 - k;
    assign lvl[k] = &addr_i[ADDR_W-1 -: TOPB];
  end

  logic unused_low;
  assign unused_low = ^addr_i[ADDR_W-LEVELS-1:0];

  assign hit_o = lvl[rng_i];
endmodule

// File: rtl/wp_status_reg.sv
module wp_status_reg
  import flash_wp_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  op_e             op_i,
  input  logic            lock_d_i,
  input  logic [RNG_W-1:0] rng_d_i,
  input  logic            locked_i,
  input  logic            hit_i,
  output nv_t             nv_o,
  output logic            wel_o,
  output logic            grant_o,
  output logic            deny_o
);
  nv_t  nv_q;
  logic wel_q;

  always_comb begin
    grant_o = 1'b0;
    deny_o  = 1'b0;
    unique case (op_i)
      OP_WREN:  grant_o = 1'b1;
      OP_WRSR:  begin grant_o = wel_q & ~locked_i;  deny_o = ~grant_o; end
      OP_ARRAY: begin grant_o = wel_q & ~hit_i;     deny_o = ~grant_o; end
      default:  ;
    endcase
  end

  // retained bits: no reset
  always_ff @(posedge clk_i) begin
    if (op_i == OP_WRSR && grant_o) begin
      nv_q.lock <= lock_d_i;
      nv_q.rng  <= rng_d_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  wel_q <= 1'b0;
    else if (op_i == OP_WREN)     wel_q <= 1'b1;
    else if (op_i != OP_IDLE)     wel_q <= 1'b0;
  end

  assign nv_o  = nv_q;
  assign wel_o = wel_q;
endmodule

// File: rtl/flash_wp_guard.sv
module flash_wp_guard
  import flash_wp_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wp_ni,
  input  logic              busy_i,
  input  logic              cmd_wren_i,
  input  logic              cmd_wrsr_i,
  input  logic [7:0]        wrsr_data_i,
  input  logic              cmd_prog_i,
  input  logic              cmd_erase_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [7:0]        status_o,
  output logic              accept_o,
  output logic              reject_o,
  output logic              debug_lock_o
);
  op_e  op;
  logic wp_level;
  logic locked;
  logic range_hit;
  nv_t  nv;
  logic wel;
  logic grant, deny;
  logic accept_q, reject_q;

  always_comb begin
    if (cmd_wrsr_i)                    op = OP_WRSR;
    else if (cmd_prog_i | cmd_erase_i) op = OP_ARRAY;
    else if (cmd_wren_i)               op = OP_WREN;
    else                               op = OP_IDLE;
  end

  wp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (wp_ni),
    .sync_o  (wp_level)
  );

  wp_region #(.ADDR_W(ADDR_W), .RNG_W(RNG_W)) u_region (
    .addr_i (addr_i),
    .rng_i  (nv.rng),
    .hit_o  (range_hit)
  );

  assign locked = nv.lock & ~wp_level;

  wp_status_reg u_sr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .op_i     (op),
    .lock_d_i (wrsr_data_i[SR_LOCK]),
    .rng_d_i  (wrsr_data_i[SR_RNG_HI:SR_RNG_LO]),
    .locked_i (locked),
    .hit_i    (range_hit),
    .nv_o     (nv),
    .wel_o    (wel),
    .grant_o  (grant),
    .deny_o   (deny)
  );

  logic unused_data;
  assign unused_data = ^{wrsr_data_i[6:5], wrsr_data_i[1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      accept_q <= 1'b0;
      reject_q <= 1'b0;
    end else begin
      accept_q <= grant;
      reject_q <= deny;
    end
  end

  assign accept_o     = accept_q;
  assign reject_o     = reject_q;
  assign status_o     = pack_status(nv, wel, busy_i);
  assign debug_lock_o = ~wp_level;
endmodule

// File: rtl/flash_wp_guard_chk.sv
module flash_wp_guard_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wp_ni,
  input logic       cmd_wrsr_i,
  input logic       cmd_prog_i,
  input logic       cmd_erase_i,
  input logic [7:0] status_o,
  input logic       accept_o,
  input logic       reject_o,
  input logic       debug_lock_o,
  input logic       wp_level,
  input logic       range_hit
);
  logic       wr_any;
  logic [1:0] since_rst;

  assign wr_any = cmd_wrsr_i | cmd_prog_i | cmd_erase_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              since_rst <= '0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
  end

  assert_locked_reject_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wrsr_i && status_o[7] && !wp_level) |=> (reject_o && $stable(status_o[7:2])));

  assert_locked_readonly_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[7] && !wp_level) |=> $stable(status_o[7:2]));

  assert_unlocked_accept_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wrsr_i && !status_o[7] && status_o[1]) |=> accept_o);

  assert_debug_follows_pin_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd2) |-> (debug_lock_o == !$past(wp_ni, 2)));

  assert_range_reject_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cmd_prog_i || cmd_erase_i) && !cmd_wrsr_i && range_hit) |=> reject_o);

  assert_no_wel_reject_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_any && !status_o[1]) |=> reject_o);

  assert_wel_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_any |=> !status_o[1]);

  assert_pulse_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(accept_o && reject_o));
endmodule

bind flash_wp_guard flash_wp_guard_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wp_ni        (wp_ni),
  .cmd_wrsr_i   (cmd_wrsr_i),
  .cmd_prog_i   (cmd_prog_i),
  .cmd_erase_i  (cmd_erase_i),
  .status_o     (status_o),
  .accept_o     (accept_o),
  .reject_o     (reject_o),
  .debug_lock_o (debug_lock_o),
  .wp_level     (wp_level),
  .range_hit    (range_hit)
);

// File: tb/flash_wp_guard_bench.sv
`timescale 1ns/1ps
module flash_wp_guard_bench;
  localparam int AW = 10;
  localparam int MAX_CYC = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wp_n = 1'b1, busy = 1'b0;
  logic wren = 1'b0, wrsr = 1'b0, prog = 1'b0, erase = 1'b0;
  logic [7:0] wdata = '0;
  logic [AW-1:0] addr = '0;
  logic [7:0] status;
  logic acc_o, rej_o, dbg;

  int checks = 0, fails = 0;
  bit done = 0;
  logic acc, rej;
  logic [7:0] stat;

  always #2.5 clk = ~clk;

  flash_wp_guard #(.ADDR_W(AW)) u_flash_wp_guard (
    .clk_i(clk), .rst_ni(rst_n), .wp_ni(wp_n), .busy_i(busy),
    .cmd_wren_i(wren), .cmd_wrsr_i(wrsr), .wrsr_data_i(wdata),
    .cmd_prog_i(prog), .cmd_erase_i(erase), .addr_i(addr),
    .status_o(status), .accept_o(acc_o), .reject_o(rej_o), .debug_lock_o(dbg)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // kind: 0 wren, 1 wrsr, 2 prog, 3 erase
  task automatic cmd(input int kind, input logic [7:0] d, input logic [AW-1:0] a);
    @(negedge clk);
    wdata = d; addr = a;
    wren = (kind == 0); wrsr = (kind == 1); prog = (kind == 2); erase = (kind == 3);
    @(negedge clk);
    wren = 0; wrsr = 0; prog = 0; erase = 0;
    acc = acc_o; rej = rej_o; stat = status;
    @(negedge clk);
    if (acc_o || rej_o) begin
      checks++; fails++;
      $display("FAIL R11 pulse longer than one cycle: actual 1 expected 0");
    end
  endtask

  task automatic set_pin(input logic v);
    @(negedge clk); wp_n = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic load_status(input logic [7:0] d, input string req);
    cmd(0, 8'h00, '0);
    chk(req, "wren accept", acc, 1);
    cmd(1, d, '0);
    chk(req, "wrsr accept", acc, 1);
  endtask

  task automatic t_reset;
    chk("R11", "accept at reset", acc_o, 0);
    chk("R11", "reject at reset", rej_o, 0);
    chk("R4", "wel/busy at reset", status[1:0], 0);
    chk("R6", "debug lock at reset", dbg, 0);
  endtask

  task automatic t_layout;
    cmd(0, 8'h00, '0);
    chk("R10", "wren accept", acc, 1);
    chk("R10", "wel set", stat[1], 1);
    cmd(1, 8'hFF, '0);
    chk("R5", "wrsr accept pin high", acc, 1);
    chk("R7", "status byte", stat, 8'h9C);
    @(negedge clk); busy = 1; #1;
    chk("R7", "busy bit", status, 8'h9D);
    @(negedge clk); busy = 0;
  endtask

  task automatic t_locked;
    set_pin(0);
    cmd(0, 8'h00, '0);
    chk("R10", "wren in locked mode", acc, 1);
    cmd(1, 8'h00, '0);
    chk("R2", "locked wrsr reject", rej, 1);
    chk("R2", "locked wrsr accept", acc, 0);
    chk("R3", "status kept", stat, 8'h9C);
    chk("R9", "wel cleared after reject", stat[1], 0);
    set_pin(1);
    cmd(0, 8'h00, '0);
    cmd(1, 8'h00, '0);
    chk("R1", "pin high unlocks", acc, 1);
    chk("R1", "status cleared", stat, 8'h00);
  endtask

  task automatic t_unlocked_pin_low;
    set_pin(0);
    cmd(0, 8'h00, '0);
    cmd(1, 8'h0C, '0);
    chk("R5", "wrsr accepted lock 0 pin low", acc, 1);
    chk("R5", "status loaded", stat, 8'h0C);
    set_pin(1);
  endtask

  task automatic t_debug;
    @(negedge clk); wp_n = 0;
    @(negedge clk);
    chk("R6", "lock after one edge", dbg, 0);
    @(negedge clk);
    chk("R6", "lock after two edges", dbg, 1);
    @(negedge clk); wp_n = 1;
    @(negedge clk);
    chk("R6", "release after one edge", dbg, 1);
    @(negedge clk);
    chk("R6", "release after two edges", dbg, 0);
  endtask

  task automatic try_arr(input int kind, input logic [AW-1:0] a, input bit exp_acc, input string what);
    cmd(0, 8'h00, '0);
    cmd(kind, 8'h00, a);
    chk("R8", what, acc, exp_acc);
    chk("R8", {what, " reject"}, rej, !exp_acc);
  endtask

  task automatic t_regions;
    load_status(8'h00, "R8");
    try_arr(2, 10'd1023, 1, "code0 top addr");
    load_status(8'h04, "R8");
    try_arr(2, 10'd1007, 1, "code1 below edge");
    try_arr(3, 10'd1008, 0, "code1 at edge");
    load_status(8'h0C, "R8");
    try_arr(2, 10'd959, 1, "code3 below edge");
    try_arr(2, 10'd960, 0, "code3 at edge");
    load_status(8'h18, "R8");
    try_arr(3, 10'd511, 1, "code6 below edge");
    try_arr(2, 10'd512, 0, "code6 at edge");
    load_status(8'h1C, "R8");
    try_arr(3, 10'd0, 0, "code7 addr 0");
  endtask

  task automatic t_wel;
    load_status(8'h00, "R9");
    cmd(2, 8'h00, 10'd5);
    chk("R9", "prog without wel", rej, 1);
    cmd(1, 8'h1C, '0);
    chk("R9", "wrsr without wel", rej, 1);
    chk("R9", "status unchanged", stat, 8'h00);
    cmd(0, 8'h00, '0);
    cmd(2, 8'h00, 10'd5);
    chk("R9", "prog with wel", acc, 1);
    chk("R9", "wel cleared after accept", stat[1], 0);
    @(negedge clk); wren = 1; prog = 1; addr = 10'd5;
    @(negedge clk); wren = 0; prog = 0;
    chk("R11", "prog wins over wren", rej_o, 1);
    chk("R11", "wel not set", status[1], 0);
  endtask

  task automatic t_retain;
    load_status(8'h8C, "R4");
    cmd(0, 8'h00, '0);
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R4", "retained status, wel cleared", status, 8'h8C);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_layout();
    t_locked();
    t_unlocked_pin_low();
    t_debug();
    t_regions();
    t_wel();
    t_retain();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (MAX_CYC) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule